// File: doc/BRIEF.md
# DMA Remapping Translation Cache with Prefetch Buffer

This block caches address translations for DMA remapping. A request names a protection domain and a virtual I/O page number, and the block returns the host physical page number when it holds that translation. Two structures hold translations. The main cache is set associative: 16 sets of 2 ways by default, 32 entries in all. Beside it sits a small fully associative prefetch buffer of 4 entries by default. A lookup searches both structures at once, and the answer appears in the same cycle.

The page walker supplies translations through the fill port. Speculative translations arrive through the prefetch port and stay in the prefetch buffer until a lookup uses one of them. That first use moves the entry into the main cache. Each translation carries a transient flag. When the eviction-hint enable is set, the main cache evicts transient entries first.

An invalidate port removes a translation from both structures. The block does one state-changing operation per cycle, chosen by a fixed priority.

Top module: `dma_xlate_cache`

## Requirements
- R1: After reset, no lookup hits (`lkHit` = 0) until a translation has been written.
- R2: A lookup returns `lkHit` = 1 and the stored `lkPpn` in the same cycle it is presented. The set is chosen by the low 4 bits of the page number. The domain takes part only in the tag compare, so the same page number under a different domain misses, and so does a different page number in the same set.
- R3: With the hint enable low and both ways of a set valid, a new main-cache entry replaces the least recently used way. Both a lookup hit and a write count as a use.
- R4: With the hint enable high, a valid transient way in the target set is evicted before any non-transient way, even if it is the most recently used. If several ways are transient, the least recently used of them is evicted.
- R5: An invalid way in the target set is always filled before any valid way is evicted.
- R6: A fill whose domain and page are already in the main cache rewrites that entry in place. The other ways of the set keep their contents.
- R7: A prefetch fill writes only the prefetch buffer. It changes neither the contents nor the replacement order of the main cache.
- R8: A lookup that misses the main cache and hits the prefetch buffer returns `lkHit` = 1 and `lkPfHit` = 1 in that cycle. The entry then moves into the main cache, into the way that normal victim choice selects, and leaves the buffer. A repeat lookup hits with `lkPfHit` = 0.
- R9: When the prefetch buffer is full, a new prefetch replaces the entry that was written longest ago. The transient flag and the hint enable have no effect on this choice.
- R10: An invalidate clears every entry that matches its domain and page, in both the main cache and the prefetch buffer, in one cycle.
- R11: Only one state-changing operation happens per cycle, in this priority: invalidate, then fill, then prefetch fill, then the lookup's update. A lower-priority request in the same cycle is dropped. The lookup outputs still reflect the state as it was before the cycle.
- R12: A prefetch of a translation already in the main cache is dropped. A prefetch of a translation already in the buffer rewrites that slot, which then counts as newest. A fill removes any matching entry from the prefetch buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evictHintEn | input | 1 | Enables transient-first eviction in the main cache |
| lkValid | input | 1 | Lookup request |
| lkDomain | input | 4 | Lookup domain |
| lkVpn | input | 20 | Lookup virtual I/O page number |
| lkHit | output | 1 | Lookup hit in either structure |
| lkPfHit | output | 1 | Hit served by the prefetch buffer |
| lkPpn | output | 24 | Translated host physical page number |
| fillValid | input | 1 | Page-walk result write |
| fillDomain | input | 4 | Fill domain |
| fillVpn | input | 20 | Fill page number |
| fillPpn | input | 24 | Fill physical page number |
| fillTransient | input | 1 | Fill transient flag |
| pfValid | input | 1 | Prefetch write |
| pfDomain | input | 4 | Prefetch domain |
| pfVpn | input | 20 | Prefetch page number |
| pfPpn | input | 24 | Prefetch physical page number |
| pfTransient | input | 1 | Prefetch transient flag |
| invValid | input | 1 | Invalidate request |
| invDomain | input | 4 | Invalidate domain |
| invVpn | input | 20 | Invalidate page number |

## Verification
The hardest case to reach is a transient entry that is also the most recently used way, in a full set with hints enabled. The same applies to a prefetch-buffer hit whose promotion has to evict from such a set. Random traffic seldom builds either case. Directed sequences therefore fill one set, touch the transient way last, and only then force a new entry into that set. Constrained random traffic then draws page numbers from 64 values and domains from two, so sets conflict constantly. It mixes fills, prefetches, invalidates and colliding requests, and a bench model of both structures predicts every lookup.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  typedef struct packed {
    logic invalidate;
    logic mainWrite;
    logic srcPromote;
    logic touch;
    logic pfWrite;
  } strobe_t;
endpackage

// File: rtl/xlate_age_order.sv
module xlate_age_order #(
  parameter int N = 2,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 touch,
  input  logic [IW-1:0]        touchIdx,
  output logic [N-1:0][IW-1:0] ages
);
  // ages form a permutation of 0..N-1; 0 is newest, N-1 oldest
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < N; i++) ages[i] <= IW'(i);
    end else if (touch) begin
      for (int i = 0; i < N; i++) begin
        if (IW'(i) == touchIdx) ages[i] <= '0;
        else if (ages[i] < ages[touchIdx]) ages[i] <= ages[i] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/xlate_dp.sv
module xlate_dp
  import xlate_pkg::*;
#(
  parameter int VPN_W = 20,
  parameter int PPN_W = 24,
  parameter int DOM_W = 4,
  parameter int SETS = 16,
  parameter int WAYS = 2,
  parameter int PF_DEPTH = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int PF_W = (PF_DEPTH > 1) ? $clog2(PF_DEPTH) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strb,
  input  logic [SET_W-1:0]    tgtSet,
  input  logic [WAY_W-1:0]    wayIdx,
  input  logic [PF_W-1:0]     pfSlot,
  input  logic [PF_W-1:0]     promoteSlot,
  input  logic [PF_DEPTH-1:0] pfClearMask,
  input  logic [DOM_W-1:0]    lkDomain,
  input  logic [VPN_W-1:0]    lkVpn,
  input  logic [DOM_W-1:0]    fillDomain,
  input  logic [VPN_W-1:0]    fillVpn,
  input  logic [PPN_W-1:0]    fillPpn,
  input  logic                fillTransient,
  input  logic [DOM_W-1:0]    pfDomain,
  input  logic [VPN_W-1:0]    pfVpn,
  input  logic [PPN_W-1:0]    pfPpn,
  input  logic                pfTransient,
  input  logic [DOM_W-1:0]    invDomain,
  input  logic [VPN_W-1:0]    invVpn,
  output logic [WAYS-1:0]     lkMainMatch,
  output logic [PF_DEPTH-1:0] lkPfMatch,
  output logic [WAYS-1:0]     flMainMatch,
  output logic [PF_DEPTH-1:0] flPfMatch,
  output logic [WAYS-1:0]     pfMainMatch,
  output logic [PF_DEPTH-1:0] pfPfMatch,
  output logic [WAYS-1:0]     tgtValid,
  output logic [WAYS-1:0]     tgtTrans,
  output logic [PF_DEPTH-1:0] pfValidVec,
  output logic [PPN_W-1:0]    lkPpn
);
  localparam int TAG_W = VPN_W - SET_W;

  logic             mValid [SETS][WAYS];
  logic [TAG_W-1:0] mTag   [SETS][WAYS];
  logic [DOM_W-1:0] mDom   [SETS][WAYS];
  logic [PPN_W-1:0] mPpn   [SETS][WAYS];
  logic             mTrans [SETS][WAYS];

  logic             pValid [PF_DEPTH];
  logic [VPN_W-1:0] pVpn   [PF_DEPTH];
  logic [DOM_W-1:0] pDom   [PF_DEPTH];
  logic [PPN_W-1:0] pPpn   [PF_DEPTH];
  logic             pTrans [PF_DEPTH];

  logic [WAYS-1:0]  invMainMatch;
  logic [PF_DEPTH-1:0] invPfMatch;
  logic [SET_W-1:0] lkSet, flSet, pfSet, invSet;

  assign lkSet  = lkVpn[SET_W-1:0];
  assign flSet  = fillVpn[SET_W-1:0];
  assign pfSet  = pfVpn[SET_W-1:0];
  assign invSet = invVpn[SET_W-1:0];

  // tag compare for every way of each port's set
  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      lkMainMatch[w]  = mValid[lkSet][w] && mTag[lkSet][w] == lkVpn[VPN_W-1:SET_W]
                        && mDom[lkSet][w] == lkDomain;
      flMainMatch[w]  = mValid[flSet][w] && mTag[flSet][w] == fillVpn[VPN_W-1:SET_W]
                        && mDom[flSet][w] == fillDomain;
      pfMainMatch[w]  = mValid[pfSet][w] && mTag[pfSet][w] == pfVpn[VPN_W-1:SET_W]
                        && mDom[pfSet][w] == pfDomain;
      invMainMatch[w] = mValid[invSet][w] && mTag[invSet][w] == invVpn[VPN_W-1:SET_W]
                        && mDom[invSet][w] == invDomain;
      tgtValid[w]     = mValid[tgtSet][w];
      tgtTrans[w]     = mValid[tgtSet][w] && mTrans[tgtSet][w];
    end
  end

  // full compare across the prefetch buffer
  always_comb begin
    for (int p = 0; p < PF_DEPTH; p++) begin
      pfValidVec[p] = pValid[p];
      lkPfMatch[p]  = pValid[p] && pVpn[p] == lkVpn  && pDom[p] == lkDomain;
      flPfMatch[p]  = pValid[p] && pVpn[p] == fillVpn && pDom[p] == fillDomain;
      pfPfMatch[p]  = pValid[p] && pVpn[p] == pfVpn  && pDom[p] == pfDomain;
      invPfMatch[p] = pValid[p] && pVpn[p] == invVpn && pDom[p] == invDomain;
    end
  end

  // main cache wins over the buffer when forming the result
  always_comb begin
    lkPpn = '0;
    for (int p = 0; p < PF_DEPTH; p++)
      if (lkPfMatch[p]) lkPpn = pPpn[p];
    for (int w = 0; w < WAYS; w++)
      if (lkMainMatch[w]) lkPpn = mPpn[lkSet][w];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) mValid[s][w] <= 1'b0;
      for (int p = 0; p < PF_DEPTH; p++) pValid[p] <= 1'b0;
    end else begin
      if (strb.invalidate) begin
        for (int w = 0; w < WAYS; w++)
          if (invMainMatch[w]) mValid[invSet][w] <= 1'b0;
        for (int p = 0; p < PF_DEPTH; p++)
          if (invPfMatch[p]) pValid[p] <= 1'b0;
      end
      if (strb.mainWrite) mValid[tgtSet][wayIdx] <= 1'b1;
      for (int p = 0; p < PF_DEPTH; p++)
        if (pfClearMask[p]) pValid[p] <= 1'b0;
      if (strb.pfWrite) pValid[pfSlot] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.mainWrite) begin
      if (strb.srcPromote) begin
        mTag[tgtSet][wayIdx]   <= pVpn[promoteSlot][VPN_W-1:SET_W];
        mDom[tgtSet][wayIdx]   <= pDom[promoteSlot];
        mPpn[tgtSet][wayIdx]   <= pPpn[promoteSlot];
        mTrans[tgtSet][wayIdx] <= pTrans[promoteSlot];
      end else begin
        mTag[tgtSet][wayIdx]   <= fillVpn[VPN_W-1:SET_W];
        mDom[tgtSet][wayIdx]   <= fillDomain;
        mPpn[tgtSet][wayIdx]   <= fillPpn;
        mTrans[tgtSet][wayIdx] <= fillTransient;
      end
    end
    if (strb.pfWrite) begin
      pVpn[pfSlot]   <= pfVpn;
      pDom[pfSlot]   <= pfDomain;
      pPpn[pfSlot]   <= pfPpn;
      pTrans[pfSlot] <= pfTransient;
    end
  end
endmodule

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
#(
  parameter int SETS = 16,
  parameter int WAYS = 2,
  parameter int PF_DEPTH = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int PF_W = (PF_DEPTH > 1) ? $clog2(PF_DEPTH) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                evictHintEn,
  input  logic                lkValid,
  input  logic                fillValid,
  input  logic                pfValid,
  input  logic                invValid,
  input  logic [SET_W-1:0]    lkSet,
  input  logic [SET_W-1:0]    fillSet,
  input  logic [WAYS-1:0]     lkMainMatch,
  input  logic [PF_DEPTH-1:0] lkPfMatch,
  input  logic [WAYS-1:0]     flMainMatch,
  input  logic [PF_DEPTH-1:0] flPfMatch,
  input  logic [WAYS-1:0]     pfMainMatch,
  input  logic [PF_DEPTH-1:0] pfPfMatch,
  input  logic [WAYS-1:0]     tgtValid,
  input  logic [WAYS-1:0]     tgtTrans,
  input  logic [PF_DEPTH-1:0] pfValidVec,
  output strobe_t             strb,
  output logic [SET_W-1:0]    tgtSet,
  output logic [WAY_W-1:0]    wayIdx,
  output logic [PF_W-1:0]     pfSlot,
  output logic [PF_W-1:0]     promoteSlot,
  output logic [PF_DEPTH-1:0] pfClearMask,
  output logic                lkHit,
  output logic                lkPfHit
);
  logic [SETS-1:0][WAYS-1:0][WAY_W-1:0] mAges;
  logic [PF_DEPTH-1:0][PF_W-1:0]        pAges;
  logic [WAYS-1:0][WAY_W-1:0]           setAges;
  logic [WAY_W-1:0] victim, flWay, lkWay, bestAge;
  logic [PF_W-1:0]  pfVictim, pfMatchSlot;
  logic doInv, doFill, doPf, doLk, mainHit, pfHitAny, found;

  // one replacement-order tracker per set
  for (genvar s = 0; s < SETS; s++) begin : g_set_age
    xlate_age_order #(.N(WAYS)) u_age (
      .clk(clk), .rstN(rstN),
      .touch(strb.touch && tgtSet == SET_W'(s)),
      .touchIdx(wayIdx), .ages(mAges[s])
    );
  end

  // insertion order for the prefetch buffer
  xlate_age_order #(.N(PF_DEPTH)) u_pf_age (
    .clk(clk), .rstN(rstN), .touch(strb.pfWrite),
    .touchIdx(pfSlot), .ages(pAges)
  );

  always_comb begin
    doInv    = invValid;
    doFill   = !invValid && fillValid;
    doPf     = !invValid && !fillValid && pfValid;
    doLk     = !invValid && !fillValid && !pfValid && lkValid;
    mainHit  = |lkMainMatch;
    pfHitAny = |lkPfMatch;
    lkHit    = lkValid && (mainHit || pfHitAny);
    lkPfHit  = lkValid && !mainHit && pfHitAny;
    tgtSet   = doFill ? fillSet : lkSet;
    setAges  = mAges[tgtSet];
  end

  // match encoders
  always_comb begin
    flWay = '0; lkWay = '0; pfMatchSlot = '0; promoteSlot = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (flMainMatch[w]) flWay = WAY_W'(w);
      if (lkMainMatch[w]) lkWay = WAY_W'(w);
    end
    for (int p = 0; p < PF_DEPTH; p++) begin
      if (pfPfMatch[p]) pfMatchSlot = PF_W'(p);
      if (lkPfMatch[p]) promoteSlot = PF_W'(p);
    end
  end

  // main-cache victim: free way, else oldest transient (hints on), else oldest
  always_comb begin
    victim = '0; found = 1'b0; bestAge = '0;
    for (int w = WAYS-1; w >= 0; w--)
      if (!tgtValid[w]) begin victim = WAY_W'(w); found = 1'b1; end
    if (!found && evictHintEn && |tgtTrans) begin
      for (int w = 0; w < WAYS; w++)
        if (tgtTrans[w] && (!found || setAges[w] > bestAge)) begin
          victim = WAY_W'(w); bestAge = setAges[w]; found = 1'b1;
        end
    end
    if (!found) begin
      for (int w = 0; w < WAYS; w++)
        if (setAges[w] == WAY_W'(WAYS-1)) victim = WAY_W'(w);
    end
  end

  // prefetch slot: lowest free, else the one written longest ago
  always_comb begin
    pfVictim = '0;
    for (int p = 0; p < PF_DEPTH; p++)
      if (pAges[p] == PF_W'(PF_DEPTH-1)) pfVictim = PF_W'(p);
    for (int p = PF_DEPTH-1; p >= 0; p--)
      if (!pfValidVec[p]) pfVictim = PF_W'(p);
  end

  always_comb begin
    strb = '0;
    wayIdx = victim;
    pfSlot = pfVictim;
    pfClearMask = '0;
    if (doInv) begin
      strb.invalidate = 1'b1;
    end else if (doFill) begin
      strb.mainWrite = 1'b1;
      strb.touch = 1'b1;
      if (|flMainMatch) wayIdx = flWay;
      pfClearMask = flPfMatch;
    end else if (doPf) begin
      if (!(|pfMainMatch)) begin
        strb.pfWrite = 1'b1;
        if (|pfPfMatch) pfSlot = pfMatchSlot;
      end
    end else if (doLk) begin
      if (mainHit) begin
        strb.touch = 1'b1;
        wayIdx = lkWay;
      end else if (pfHitAny) begin
        strb.mainWrite = 1'b1;
        strb.srcPromote = 1'b1;
        strb.touch = 1'b1;
        pfClearMask = lkPfMatch;
      end
    end
  end
endmodule

// File: rtl/dma_xlate_cache.sv
module dma_xlate_cache
  import xlate_pkg::*;
#(
  parameter int VPN_W = 20,
  parameter int PPN_W = 24,
  parameter int DOM_W = 4,
  parameter int SETS = 16,
  parameter int WAYS = 2,
  parameter int PF_DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             evictHintEn,
  input  logic             lkValid,
  input  logic [DOM_W-1:0] lkDomain,
  input  logic [VPN_W-1:0] lkVpn,
  output logic             lkHit,
  output logic             lkPfHit,
  output logic [PPN_W-1:0] lkPpn,
  input  logic             fillValid,
  input  logic [DOM_W-1:0] fillDomain,
  input  logic [VPN_W-1:0] fillVpn,
  input  logic [PPN_W-1:0] fillPpn,
  input  logic             fillTransient,
  input  logic             pfValid,
  input  logic [DOM_W-1:0] pfDomain,
  input  logic [VPN_W-1:0] pfVpn,
  input  logic [PPN_W-1:0] pfPpn,
  input  logic             pfTransient,
  input  logic             invValid,
  input  logic [DOM_W-1:0] invDomain,
  input  logic [VPN_W-1:0] invVpn
);
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int PF_W  = (PF_DEPTH > 1) ? $clog2(PF_DEPTH) : 1;

  strobe_t             strb;
  logic [SET_W-1:0]    tgtSet;
  logic [WAY_W-1:0]    wayIdx;
  logic [PF_W-1:0]     pfSlot, promoteSlot;
  logic [PF_DEPTH-1:0] pfClearMask, lkPfMatch, flPfMatch, pfPfMatch, pfValidVec;
  logic [WAYS-1:0]     lkMainMatch, flMainMatch, pfMainMatch, tgtValid, tgtTrans;

  xlate_ctrl #(.SETS(SETS), .WAYS(WAYS), .PF_DEPTH(PF_DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .evictHintEn(evictHintEn),
    .lkValid(lkValid), .fillValid(fillValid), .pfValid(pfValid), .invValid(invValid),
    .lkSet(lkVpn[SET_W-1:0]), .fillSet(fillVpn[SET_W-1:0]),
    .lkMainMatch(lkMainMatch), .lkPfMatch(lkPfMatch),
    .flMainMatch(flMainMatch), .flPfMatch(flPfMatch),
    .pfMainMatch(pfMainMatch), .pfPfMatch(pfPfMatch),
    .tgtValid(tgtValid), .tgtTrans(tgtTrans), .pfValidVec(pfValidVec),
    .strb(strb), .tgtSet(tgtSet), .wayIdx(wayIdx), .pfSlot(pfSlot),
    .promoteSlot(promoteSlot), .pfClearMask(pfClearMask),
    .lkHit(lkHit), .lkPfHit(lkPfHit)
  );

  xlate_dp #(.VPN_W(VPN_W), .PPN_W(PPN_W), .DOM_W(DOM_W), .SETS(SETS),
             .WAYS(WAYS), .PF_DEPTH(PF_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .tgtSet(tgtSet), .wayIdx(wayIdx),
    .pfSlot(pfSlot), .promoteSlot(promoteSlot), .pfClearMask(pfClearMask),
    .lkDomain(lkDomain), .lkVpn(lkVpn),
    .fillDomain(fillDomain), .fillVpn(fillVpn), .fillPpn(fillPpn),
    .fillTransient(fillTransient),
    .pfDomain(pfDomain), .pfVpn(pfVpn), .pfPpn(pfPpn), .pfTransient(pfTransient),
    .invDomain(invDomain), .invVpn(invVpn),
    .lkMainMatch(lkMainMatch), .lkPfMatch(lkPfMatch),
    .flMainMatch(flMainMatch), .flPfMatch(flPfMatch),
    .pfMainMatch(pfMainMatch), .pfPfMatch(pfPfMatch),
    .tgtValid(tgtValid), .tgtTrans(tgtTrans), .pfValidVec(pfValidVec),
    .lkPpn(lkPpn)
  );
endmodule

// File: rtl/dma_xlate_cache_chk.sv
module dma_xlate_cache_chk #(
  parameter int VPN_W = 20,
  parameter int PPN_W = 24,
  parameter int DOM_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             lkValid,
  input logic [DOM_W-1:0] lkDomain,
  input logic [VPN_W-1:0] lkVpn,
  input logic             lkHit,
  input logic             lkPfHit,
  input logic [PPN_W-1:0] lkPpn,
  input logic             fillValid,
  input logic [DOM_W-1:0] fillDomain,
  input logic [VPN_W-1:0] fillVpn,
  input logic [PPN_W-1:0] fillPpn,
  input logic             pfValid,
  input logic [DOM_W-1:0] pfDomain,
  input logic [VPN_W-1:0] pfVpn,
  input logic             invValid,
  input logic [DOM_W-1:0] invDomain,
  input logic [VPN_W-1:0] invVpn
);
  always @(posedge clk) begin
    if (!rstN) assert_reset_miss_R1: assert (!lkHit);
  end

  assert_fill_visible_R6: assert property (@(posedge clk) disable iff (!rstN)
    fillValid && !invValid |=>
      !(lkValid && lkDomain == $past(fillDomain) && lkVpn == $past(fillVpn)
        && (!lkHit || lkPfHit || lkPpn != $past(fillPpn))));

  assert_pf_only_when_hit_R8: assert property (@(posedge clk) disable iff (!rstN)
    lkPfHit |-> lkHit);

  assert_promote_moves_R8: assert property (@(posedge clk) disable iff (!rstN)
    lkPfHit && !invValid && !fillValid && !pfValid |=>
      !(lkValid && lkDomain == $past(lkDomain) && lkVpn == $past(lkVpn)
        && (!lkHit || lkPfHit)));

  assert_prefetch_held_R7: assert property (@(posedge clk) disable iff (!rstN)
    pfValid && !invValid && !fillValid |=>
      !(lkValid && lkDomain == $past(pfDomain) && lkVpn == $past(pfVpn) && !lkHit));

  assert_invalidate_clears_R10: assert property (@(posedge clk) disable iff (!rstN)
    invValid |=>
      !(lkValid && lkDomain == $past(invDomain) && lkVpn == $past(invVpn) && lkHit));
endmodule

bind dma_xlate_cache dma_xlate_cache_chk #(.VPN_W(VPN_W), .PPN_W(PPN_W), .DOM_W(DOM_W)) u_chk (
  .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkDomain(lkDomain), .lkVpn(lkVpn),
  .lkHit(lkHit), .lkPfHit(lkPfHit), .lkPpn(lkPpn),
  .fillValid(fillValid), .fillDomain(fillDomain), .fillVpn(fillVpn), .fillPpn(fillPpn),
  .pfValid(pfValid), .pfDomain(pfDomain), .pfVpn(pfVpn),
  .invValid(invValid), .invDomain(invDomain), .invVpn(invVpn)
);

// File: tb/tb_dma_xlate_cache.sv
module tb_dma_xlate_cache;
  localparam int SETS = 16, WAYS = 2, PFD = 4;

  logic clk = 0, rstN = 0, evictHintEn = 0;
  logic lkValid = 0, fillValid = 0, pfValid = 0, invValid = 0;
  logic fillTransient = 0, pfTransient = 0;
  logic [3:0] lkDomain = 0, fillDomain = 0, pfDomain = 0, invDomain = 0;
  logic [19:0] lkVpn = 0, fillVpn = 0, pfVpn = 0, invVpn = 0;
  logic [23:0] fillPpn = 0, pfPpn = 0;
  logic lkHit, lkPfHit;
  logic [23:0] lkPpn;

  int nTests = 0, nFail = 0;

  dma_xlate_cache dut (.*);

  always #2 clk = ~clk;

  // reference model
  bit mv [SETS][WAYS]; int mvpn [SETS][WAYS]; int mdom [SETS][WAYS];
  int mppn [SETS][WAYS]; bit mtr [SETS][WAYS]; int mage [SETS][WAYS];
  bit pv [PFD]; int pvpn [PFD]; int pdom [PFD]; int pppn [PFD]; bit ptr [PFD]; int page [PFD];

  function automatic void modelReset();
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin mv[s][w] = 0; mage[s][w] = w; end
    for (int p = 0; p < PFD; p++) begin pv[p] = 0; page[p] = p; end
  endfunction

  function automatic int findMain(int d, int v);
    for (int w = 0; w < WAYS; w++)
      if (mv[v % SETS][w] && mvpn[v % SETS][w] == v && mdom[v % SETS][w] == d) return w;
    return -1;
  endfunction

  function automatic int findPf(int d, int v);
    for (int p = 0; p < PFD; p++)
      if (pv[p] && pvpn[p] == v && pdom[p] == d) return p;
    return -1;
  endfunction

  function automatic void touchMain(int s, int t);
    int a = mage[s][t];
    for (int w = 0; w < WAYS; w++) if (mage[s][w] < a) mage[s][w]++;
    mage[s][t] = 0;
  endfunction

  function automatic void touchPf(int t);
    int a = page[t];
    for (int p = 0; p < PFD; p++) if (page[p] < a) page[p]++;
    page[t] = 0;
  endfunction

  function automatic int pickVictim(int s);
    int best = -1;
    for (int w = 0; w < WAYS; w++) if (!mv[s][w]) return w;
    if (evictHintEn)
      for (int w = 0; w < WAYS; w++)
        if (mtr[s][w] && (best < 0 || mage[s][w] > mage[s][best])) best = w;
    if (best >= 0) return best;
    for (int w = 0; w < WAYS; w++) if (mage[s][w] == WAYS-1) return w;
    return 0;
  endfunction

  function automatic void writeMain(int s, int w, int d, int v, int pp, bit t);
    mv[s][w] = 1; mvpn[s][w] = v; mdom[s][w] = d; mppn[s][w] = pp; mtr[s][w] = t;
    touchMain(s, w);
  endfunction

  function automatic void modelStep();
    if (invValid) begin
      int w = findMain(int'(invDomain), int'(invVpn));
      int p = findPf(int'(invDomain), int'(invVpn));
      if (w >= 0) mv[int'(invVpn) % SETS][w] = 0;
      if (p >= 0) pv[p] = 0;
    end else if (fillValid) begin
      int s = int'(fillVpn) % SETS;
      int w = findMain(int'(fillDomain), int'(fillVpn));
      int p = findPf(int'(fillDomain), int'(fillVpn));
      if (w < 0) w = pickVictim(s);
      writeMain(s, w, int'(fillDomain), int'(fillVpn), int'(fillPpn), fillTransient);
      if (p >= 0) pv[p] = 0;
    end else if (pfValid) begin
      if (findMain(int'(pfDomain), int'(pfVpn)) < 0) begin
        int p = findPf(int'(pfDomain), int'(pfVpn));
        if (p < 0) begin
          for (int q = 0; q < PFD; q++) if (page[q] == PFD-1) p = q;
          for (int q = PFD-1; q >= 0; q--) if (!pv[q]) p = q;
        end
        pv[p] = 1; pvpn[p] = int'(pfVpn); pdom[p] = int'(pfDomain);
        pppn[p] = int'(pfPpn); ptr[p] = pfTransient; touchPf(p);
      end
    end else if (lkValid) begin
      int s = int'(lkVpn) % SETS;
      int w = findMain(int'(lkDomain), int'(lkVpn));
      int p = findPf(int'(lkDomain), int'(lkVpn));
      if (w >= 0) touchMain(s, w);
      else if (p >= 0) begin
        w = pickVictim(s);
        writeMain(s, w, pdom[p], pvpn[p], pppn[p], ptr[p]);
        pv[p] = 0;
      end
    end
  endfunction

  task automatic setIdle();
    lkValid = 0; fillValid = 0; pfValid = 0; invValid = 0;
  endtask

  // inputs are set at a falling edge; outputs checked 1 ns later
  task automatic stepCycle(string tag);
    #1;
    if (lkValid) begin
      int w = findMain(int'(lkDomain), int'(lkVpn));
      int p = findPf(int'(lkDomain), int'(lkVpn));
      bit eHit = (w >= 0) || (p >= 0);
      bit ePf = (w < 0) && (p >= 0);
      int ePpn = (w >= 0) ? mppn[int'(lkVpn) % SETS][w] : ((p >= 0) ? pppn[p] : 0);
      nTests++;
      if (lkHit !== eHit || lkPfHit !== ePf || (eHit && int'(lkPpn) != ePpn)) begin
        nFail++;
        $display("FAIL %s: dom=%0d vpn=%h hit=%0d pf=%0d ppn=%h expected hit=%0d pf=%0d ppn=%h",
                 tag, lkDomain, lkVpn, lkHit, lkPfHit, lkPpn, eHit, ePf, ePpn);
      end
    end
    @(posedge clk);
    modelStep();
    @(negedge clk);
    setIdle();
  endtask

  task automatic look(int d, int v, string tag);
    lkValid = 1; lkDomain = 4'(d); lkVpn = 20'(v); stepCycle(tag);
  endtask

  task automatic fill(int d, int v, int pp, bit t);
    fillValid = 1; fillDomain = 4'(d); fillVpn = 20'(v); fillPpn = 24'(pp);
    fillTransient = t; stepCycle("fill");
  endtask

  task automatic pref(int d, int v, int pp, bit t);
    pfValid = 1; pfDomain = 4'(d); pfVpn = 20'(v); pfPpn = 24'(pp);
    pfTransient = t; stepCycle("pref");
  endtask

  task automatic inval(int d, int v);
    invValid = 1; invDomain = 4'(d); invVpn = 20'(v); stepCycle("inval");
  endtask

  initial begin
    #(4 * 200000);
    nFail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    modelReset();
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1: empty after reset
    look(0, 5, "R1"); look(1, 32'h33, "R1");

    // R2: same-cycle hit; domain in tag; set from low bits
    fill(1, 5, 24'hA0005, 0);
    look(1, 5, "R2"); look(2, 5, "R2"); look(1, 32'h15, "R2");

    // R3 / R5: free way first, then LRU victim
    fill(0, 32'h03, 24'h100, 0); fill(0, 32'h13, 24'h101, 0);
    look(0, 32'h03, "R5"); look(0, 32'h13, "R5");
    look(0, 32'h03, "R3");
    fill(0, 32'h23, 24'h102, 0);
    look(0, 32'h13, "R3"); look(0, 32'h03, "R3"); look(0, 32'h23, "R3");

    // R4: transient way evicted though most recently used
    evictHintEn = 1;
    fill(0, 32'h04, 24'h200, 1); fill(0, 32'h14, 24'h201, 0);
    look(0, 32'h14, "R4"); look(0, 32'h04, "R4");
    fill(0, 32'h24, 24'h202, 0);
    look(0, 32'h04, "R4"); look(0, 32'h14, "R4"); look(0, 32'h24, "R4");

    // R6: in-place rewrite keeps the other way
    fill(0, 32'h24, 24'h2FF, 0);
    look(0, 32'h24, "R6"); look(0, 32'h14, "R6");

    // R7 / R8: prefetch stays apart, then promotes on first use
    evictHintEn = 0;
    fill(0, 32'h06, 24'h300, 0); fill(0, 32'h16, 24'h301, 0);
    look(0, 32'h06, "R7");
    pref(0, 32'h26, 24'h302, 0);
    look(0, 32'h16, "R7");
    look(0, 32'h26, "R8"); look(0, 32'h26, "R8");
    look(0, 32'h06, "R8"); look(0, 32'h16, "R8");

    // R9: FIFO ignores transient flags
    evictHintEn = 1;
    pref(0, 32'h08, 24'h400, 0); pref(0, 32'h09, 24'h401, 1);
    pref(0, 32'h0A, 24'h402, 0); pref(0, 32'h0B, 24'h403, 0);
    pref(0, 32'h0C, 24'h404, 0);
    look(0, 32'h08, "R9"); look(0, 32'h09, "R9"); look(0, 32'h0C, "R9");

    // R10: invalidate in both structures
    inval(0, 32'h0A); inval(0, 32'h24);
    look(0, 32'h0A, "R10"); look(0, 32'h24, "R10"); look(0, 32'h0B, "R10");

    // R11: colliding requests
    invValid = 1; invDomain = 0; invVpn = 20'h30;
    fillValid = 1; fillDomain = 0; fillVpn = 20'h30; fillPpn = 24'h500;
    lkValid = 1; lkDomain = 0; lkVpn = 20'h0B; stepCycle("R11");
    look(0, 32'h30, "R11");
    fillValid = 1; fillDomain = 0; fillVpn = 20'h31; fillPpn = 24'h501;
    pfValid = 1; pfDomain = 0; pfVpn = 20'h32; pfPpn = 24'h502;
    stepCycle("R11");
    look(0, 32'h32, "R11"); look(0, 32'h31, "R11");

    // R12: redundant prefetch dropped; fill removes buffered copy
    pref(0, 32'h31, 24'h5AA, 0);
    look(0, 32'h31, "R12");
    pref(2, 32'h3E, 24'h600, 0); pref(2, 32'h3E, 24'h601, 0);
    look(2, 32'h3E, "R12");
    pref(2, 32'h3F, 24'h700, 0);
    fill(2, 32'h3F, 24'h701, 0);
    look(2, 32'h3F, "R12");

    // constrained random traffic over a small page pool
    for (int i = 0; i < 4000; i++) begin
      int r = int'($urandom % 100);
      evictHintEn = ($urandom % 8) != 0;
      lkValid = ($urandom % 4) != 0;
      lkDomain = 4'($urandom % 2); lkVpn = 20'($urandom % 64);
      if (r < 15) begin
        fillValid = 1; fillDomain = 4'($urandom % 2); fillVpn = 20'($urandom % 64);
        fillPpn = 24'($urandom); fillTransient = 1'($urandom);
      end
      if (r >= 10 && r < 30) begin
        pfValid = 1; pfDomain = 4'($urandom % 2); pfVpn = 20'($urandom % 64);
        pfPpn = 24'($urandom); pfTransient = 1'($urandom);
      end
      if (r >= 95) begin
        invValid = 1; invDomain = 4'($urandom % 2); invVpn = 20'($urandom % 64);
      end
      stepCycle("R2");
    end

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule